// File: doc/BRIEF.md
# Processor Halt and Sleep Power-State Sequencer

This block moves a small processor core between three operating conditions: normal execution, a halted state and a sleep state. The core's instruction decoder gives it a one-cycle strobe when a halt or a sleep instruction retires. The block answers with clock enables for the core and the DMA engine, a DRAM refresh enable, low-drive overrides for the halt, status and opcode-fetch pins, and a force-high for the address and control outputs.

In the halted state the clocks keep running. The core refetches the opcode that follows the halt instruction but never executes it, and refresh, DMA and bus grants carry on. In the sleep state the core and DMA clocks are gated off, refresh stops, and the external bus is parked high unless an external master holds it.

The two states wake on different rules. A halt ends only on a request that is enabled. A sleep ends on any raised request, enabled or not. Every wake source passes through a two-flop synchroniser. On a wake the clocks come back one cycle before a single-cycle wake pulse tells the core to resume at the instruction after the halt or sleep.

Top module: `core_idle_ctrl`

## Requirements
- R1: During and after a synchronous reset (rst_n low at a clock edge) the block is in normal run. core_clk_en, dma_clk_en and refresh_en are 1. halt_low, st_low, m1_low, ctl_force_high, addr_force_high, wake_pulse and unsup_mode are all 0.
- R2: A halt_exec strobe in normal run enters the halted state at the next edge. From then on halt_low, st_low and m1_low are 1, while core_clk_en, dma_clk_en and refresh_en stay 1 and nothing is forced high.
- R3: The halted state ends only on nmi_req, on an ext_req bit whose ext_en bit is 1, or on an onchip_req bit whose onchip_en bit is 1. A request whose enable is 0 leaves halt_low at 1.
- R4: A sleep_exec strobe in normal run, with cfg_iostop, cfg_ctl_a and cfg_ctl_b all 0, enters sleep at the next edge. In sleep core_clk_en, dma_clk_en and refresh_en are 0, halt_low is 1, and st_low and m1_low are 0.
- R5: A sleep_exec strobe while any of the three configuration bits is 1 leaves the block in normal run. unsup_mode is then 1 for exactly the next cycle.
- R6: In sleep, ctl_force_high and every bit of addr_force_high equal the inverse of bus_granted.
- R7: Sleep ends on nmi_req or on any ext_req or onchip_req bit at 1, whatever the enables.
- R8: A wake request first sampled at edge k reaches the state logic at edge k+1. Edge k+2 turns the clock and refresh enables on and releases the pin overrides, with wake_pulse still 0. Edge k+3 raises wake_pulse for one cycle.
- R9: Reset taken while halted or asleep returns the block to normal run with all enables at 1 (R1 values), ahead of every other source.
- R10: halt_exec and sleep_exec have no effect outside normal run. If both arrive in the same cycle, halt_exec wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_exec | input | 1 | Halt instruction retire strobe |
| sleep_exec | input | 1 | Sleep instruction retire strobe |
| cfg_iostop | input | 1 | I/O-stop configuration bit |
| cfg_ctl_a | input | 1 | First control-register mode bit |
| cfg_ctl_b | input | 1 | Second control-register mode bit |
| bus_granted | input | 1 | External master owns the bus |
| nmi_req | input | 1 | Non-maskable request (asynchronous) |
| ext_req | input | N_EXT | External maskable requests (asynchronous) |
| ext_en | input | N_EXT | Enables for ext_req |
| onchip_req | input | N_ONCHIP | On-chip peripheral requests |
| onchip_en | input | N_ONCHIP | Enables for onchip_req |
| core_clk_en | output | 1 | Core clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| refresh_en | output | 1 | DRAM refresh enable |
| halt_low | output | 1 | Drive halt pin low |
| st_low | output | 1 | Drive status pin low |
| m1_low | output | 1 | Drive opcode-fetch pin low |
| ctl_force_high | output | 1 | Hold control outputs high |
| addr_force_high | output | ADDR_W | Hold each address line high |
| wake_pulse | output | 1 | One-cycle resume strobe to the core |
| unsup_mode | output | 1 | Sleep refused because of configuration |

## Verification
A state register stuck in or slipping out of a low-power state shows within one cycle of the deciding edge. The wrong state puts the wrong mix on the clock enables, refresh and pin overrides: halt pins low with clocks on, halt pin low with clocks off, or all released. A wake rule that reads the wrong enables leaves halt_low stuck or cleared four edges after the stimulus. A synchroniser that is one stage short or too long moves the enable restore and the wake pulse one edge away from the expected edges.

// File: rtl/idle_pkg.sv
// Package: shared state encoding for the halt/sleep sequencer.
// Assumes: a two-bit state register is enough for the four states.
package idle_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_RESUME = 2'd3
    } idle_state_e;

    localparam int CFG_W = 3;
endpackage

// File: rtl/idle_sync.sv
// Module: idle_sync
// Two-stage synchroniser, one per request bit, for asynchronous wake inputs.
// Assumes: each input bit is independent; bus skew across bits is harmless
// because any single bit alone is a valid wake reason.
module idle_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            // Two flops in series per bit; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1[b] <= 1'b0;
                    synced[b] <= 1'b0;
                end else begin
                    stage1[b] <= raw[b];
                    synced[b] <= stage1[b];
                end
            end
        end
    endgenerate

    // R8
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced[0]) |-> $past(raw[0], 2));
endmodule

// File: rtl/idle_wake_eval.sv
// Module: idle_wake_eval
// Combines synchronised requests into the two wake conditions. A halt needs
// an enabled request; a sleep needs any raised request.
// Assumes: enables are quasi-static configuration and need no synchroniser.
module idle_wake_eval #(
    parameter int N_EXT    = 3,
    parameter int N_ONCHIP = 4
) (
    input  logic                nmi_s,
    input  logic [N_EXT-1:0]    ext_s,
    input  logic [N_EXT-1:0]    ext_en,
    input  logic [N_ONCHIP-1:0] onchip_s,
    input  logic [N_ONCHIP-1:0] onchip_en,
    output logic                halt_wake,
    output logic                sleep_wake
);
    // Halt wake: masked requests plus the non-maskable one.
    always_comb begin
        halt_wake = nmi_s | (|(ext_s & ext_en)) | (|(onchip_s & onchip_en));
    end

    // Sleep wake: any raised request, masks ignored.
    always_comb begin
        sleep_wake = nmi_s | (|ext_s) | (|onchip_s);
    end
endmodule

// File: rtl/idle_fsm.sv
// Module: idle_fsm
// State sequencer: run, halted, asleep, and a one-cycle resume step in which
// clocks are back but the core has not yet been told to continue.
// Assumes: halt_exec/sleep_exec are single-cycle strobes from the decoder.
module idle_fsm
    import idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_exec,
    input  logic             sleep_exec,
    input  logic [CFG_W-1:0] cfg,
    input  logic             halt_wake,
    input  logic             sleep_wake,
    output idle_state_e      state,
    output logic             wake_pulse,
    output logic             unsup_mode
);
    idle_state_e nxt;
    logic        sleep_ok;
    logic        sleep_bad;

    // Qualify the sleep strobe against the configuration bits.
    always_comb begin
        sleep_ok  = sleep_exec && !halt_exec && (cfg == '0);
        sleep_bad = sleep_exec && !halt_exec && (cfg != '0);
    end

    // Next-state decision; strobes count only in normal run.
    always_comb begin
        nxt = state;
        case (state)
            ST_RUN: begin
                if (halt_exec)     nxt = ST_HALT;
                else if (sleep_ok) nxt = ST_SLEEP;
            end
            ST_HALT:   if (halt_wake)  nxt = ST_RESUME;
            ST_SLEEP:  if (sleep_wake) nxt = ST_RESUME;
            ST_RESUME: nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    // State register and the two registered strobes; reset wins over all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            wake_pulse <= 1'b0;
            unsup_mode <= 1'b0;
        end else begin
            state      <= nxt;
            wake_pulse <= (state == ST_RESUME);
            unsup_mode <= (state == ST_RUN) && sleep_bad;
        end
    end

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && halt_exec) |=> (state == ST_HALT));
    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_exec && !halt_exec && cfg == '0) |=> (state == ST_SLEEP));
    // R5
    cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_exec && !halt_exec && cfg != '0) |=> (state == ST_RUN && unsup_mode));
    // R8
    resume_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESUME) |=> (state == ST_RUN && wake_pulse));
    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !sleep_wake) |=> (state == ST_SLEEP));
endmodule

// File: rtl/idle_pin_ctrl.sv
// Module: idle_pin_ctrl
// Decodes the state into clock enables, refresh enable and pin overrides.
// Assumes: the pad logic ORs/ANDs these overrides into the real pin drivers.
module idle_pin_ctrl
    import idle_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  idle_state_e       state,
    input  logic              bus_granted,
    output logic              core_clk_en,
    output logic              dma_clk_en,
    output logic              refresh_en,
    output logic              halt_low,
    output logic              st_low,
    output logic              m1_low,
    output logic              ctl_force_high,
    output logic [ADDR_W-1:0] addr_force_high
);
    logic asleep;
    logic halted;
    logic park;

    // State decode shared by all outputs.
    always_comb begin
        asleep = (state == ST_SLEEP);
        halted = (state == ST_HALT);
        park   = asleep && !bus_granted;
    end

    // Clock, refresh and status-pin overrides.
    always_comb begin
        core_clk_en    = !asleep;
        dma_clk_en     = !asleep;
        refresh_en     = !asleep;
        halt_low       = asleep || halted;
        st_low         = halted;
        m1_low         = halted;
        ctl_force_high = park;
    end

    generate
        for (genvar a = 0; a < ADDR_W; a++) begin : g_addr
            // Each address line parks high in sleep when the bus is ours.
            always_comb addr_force_high[a] = park;
        end
    endgenerate
endmodule

// File: rtl/core_idle_ctrl.sv
// Module: core_idle_ctrl (top)
// Halt/sleep power-state sequencer for a small processor core.
// Assumes: rst_n is synchronous to clk; request inputs may be asynchronous.
module core_idle_ctrl
    import idle_pkg::*;
#(
    parameter int N_EXT    = 3,
    parameter int N_ONCHIP = 4,
    parameter int ADDR_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_exec,
    input  logic                sleep_exec,
    input  logic                cfg_iostop,
    input  logic                cfg_ctl_a,
    input  logic                cfg_ctl_b,
    input  logic                bus_granted,
    input  logic                nmi_req,
    input  logic [N_EXT-1:0]    ext_req,
    input  logic [N_EXT-1:0]    ext_en,
    input  logic [N_ONCHIP-1:0] onchip_req,
    input  logic [N_ONCHIP-1:0] onchip_en,
    output logic                core_clk_en,
    output logic                dma_clk_en,
    output logic                refresh_en,
    output logic                halt_low,
    output logic                st_low,
    output logic                m1_low,
    output logic                ctl_force_high,
    output logic [ADDR_W-1:0]   addr_force_high,
    output logic                wake_pulse,
    output logic                unsup_mode
);
    localparam int REQ_W = 1 + N_EXT + N_ONCHIP;

    logic [REQ_W-1:0]    req_raw;
    logic [REQ_W-1:0]    req_s;
    logic                nmi_s;
    logic [N_EXT-1:0]    ext_s;
    logic [N_ONCHIP-1:0] onchip_s;
    logic                halt_wake;
    logic                sleep_wake;
    idle_state_e         state;

    // Pack and unpack the request bundle around the synchroniser.
    always_comb begin
        req_raw  = {onchip_req, ext_req, nmi_req};
        nmi_s    = req_s[0];
        ext_s    = req_s[N_EXT:1];
        onchip_s = req_s[REQ_W-1:N_EXT+1];
    end

    idle_sync #(.W(REQ_W)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (req_raw),
        .synced (req_s)
    );

    idle_wake_eval #(.N_EXT(N_EXT), .N_ONCHIP(N_ONCHIP)) i_wake (
        .nmi_s      (nmi_s),
        .ext_s      (ext_s),
        .ext_en     (ext_en),
        .onchip_s   (onchip_s),
        .onchip_en  (onchip_en),
        .halt_wake  (halt_wake),
        .sleep_wake (sleep_wake)
    );

    idle_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_exec  (halt_exec),
        .sleep_exec (sleep_exec),
        .cfg        ({cfg_iostop, cfg_ctl_a, cfg_ctl_b}),
        .halt_wake  (halt_wake),
        .sleep_wake (sleep_wake),
        .state      (state),
        .wake_pulse (wake_pulse),
        .unsup_mode (unsup_mode)
    );

    idle_pin_ctrl #(.ADDR_W(ADDR_W)) i_pins (
        .state           (state),
        .bus_granted     (bus_granted),
        .core_clk_en     (core_clk_en),
        .dma_clk_en      (dma_clk_en),
        .refresh_en      (refresh_en),
        .halt_low        (halt_low),
        .st_low          (st_low),
        .m1_low          (m1_low),
        .ctl_force_high  (ctl_force_high),
        .addr_force_high (addr_force_high)
    );

    // R8
    clk_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(core_clk_en) && $past(refresh_en)));
    // R4
    sleep_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> (!refresh_en && halt_low && !m1_low));
    // R9
    reset_exit_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (core_clk_en && refresh_en && !halt_low));
endmodule

// File: tb/test_core_idle_ctrl.sv
`timescale 1ns/1ps
module test_core_idle_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 0, sleep_exec = 0;
    logic cfg_iostop = 0, cfg_ctl_a = 0, cfg_ctl_b = 0;
    logic bus_granted = 0, nmi_req = 0;
    logic [2:0] ext_req = '0, ext_en = '0;
    logic [3:0] onchip_req = '0, onchip_en = '0;
    logic core_clk_en, dma_clk_en, refresh_en, halt_low, st_low, m1_low;
    logic ctl_force_high, wake_pulse, unsup_mode;
    logic [19:0] addr_force_high;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    core_idle_ctrl i_core_idle_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .sleep_exec(sleep_exec),
        .cfg_iostop(cfg_iostop), .cfg_ctl_a(cfg_ctl_a), .cfg_ctl_b(cfg_ctl_b),
        .bus_granted(bus_granted), .nmi_req(nmi_req), .ext_req(ext_req),
        .ext_en(ext_en), .onchip_req(onchip_req), .onchip_en(onchip_en),
        .core_clk_en(core_clk_en), .dma_clk_en(dma_clk_en), .refresh_en(refresh_en),
        .halt_low(halt_low), .st_low(st_low), .m1_low(m1_low),
        .ctl_force_high(ctl_force_high), .addr_force_high(addr_force_high),
        .wake_pulse(wake_pulse), .unsup_mode(unsup_mode)
    );

    // Vector: ext_req[16:14] ext_en[13:11] on_req[10:7] on_en[6:3] nmi[2] halt_wakes[1] sleep_wakes[0]
    localparam logic [16:0] VEC [0:7] = '{
        {3'b000, 3'b000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0},
        {3'b000, 3'b000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1},
        {3'b001, 3'b001, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1},
        {3'b100, 3'b011, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1},
        {3'b000, 3'b000, 4'b1000, 4'b1000, 1'b0, 1'b1, 1'b1},
        {3'b000, 3'b000, 4'b0010, 4'b1101, 1'b0, 1'b0, 1'b1},
        {3'b000, 3'b111, 4'b0000, 4'b1111, 1'b0, 1'b0, 1'b0},
        {3'b010, 3'b010, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1}
    };

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; tick(1); rst_n = 1;
    endtask

    // 9-bit output snapshot: clk,dma,ref,halt,st,m1,ctlf,pulse,unsup
    function automatic int outs();
        return {core_clk_en, dma_clk_en, refresh_en, halt_low, st_low, m1_low,
                ctl_force_high, wake_pulse, unsup_mode};
    endfunction

    task automatic apply_vec(input logic [16:0] v);
        ext_req = v[16:14]; ext_en = v[13:11];
        onchip_req = v[10:7]; onchip_en = v[6:3]; nmi_req = v[2];
    endtask

    task automatic clear_req();
        ext_req = '0; ext_en = '0; onchip_req = '0; onchip_en = '0; nmi_req = 0;
    endtask

    initial begin
        tick(1);
        // R1: reset state
        chk(outs() == 9'b111_000_000, "R1", outs(), 9'b111_000_000);
        chk(addr_force_high == '0, "R1", addr_force_high, 0);
        rst_n = 1; tick(1);

        // Vector walk: halted and asleep wake rules
        for (int i = 0; i < 8; i++) begin
            do_reset();
            halt_exec = 1; tick(1); halt_exec = 0;
            // R2: halted pins low, clocks running
            chk(outs() == 9'b111_111_000, "R2", outs(), 9'b111_111_000);
            apply_vec(VEC[i]); tick(4);
            // R3: halt wake only on enabled request
            chk(halt_low == !VEC[i][1], "R3", halt_low, !VEC[i][1]);
            clear_req(); do_reset();

            sleep_exec = 1; tick(1); sleep_exec = 0;
            // R4: sleep gates clocks and refresh
            chk(outs() == 9'b000_100_100, "R4", outs(), 9'b000_100_100);
            apply_vec(VEC[i]); tick(4);
            // R7: sleep wake on any request
            chk(core_clk_en == VEC[i][0], "R7", core_clk_en, VEC[i][0]);
            clear_req();
        end

        // R8: wake timing from sleep
        do_reset();
        sleep_exec = 1; tick(1); sleep_exec = 0;
        nmi_req = 1; tick(2);
        chk(core_clk_en == 0, "R8 early", core_clk_en, 0);
        nmi_req = 0; tick(1);
        chk(outs() == 9'b111_000_000, "R8 restore", outs(), 9'b111_000_000);
        tick(1);
        chk(wake_pulse == 1, "R8 pulse", wake_pulse, 1);
        tick(1);
        chk(wake_pulse == 0, "R8 pulse width", wake_pulse, 0);

        // R5: configuration bits block sleep
        for (int c = 1; c < 8; c++) begin
            do_reset();
            {cfg_iostop, cfg_ctl_a, cfg_ctl_b} = c[2:0];
            sleep_exec = 1; tick(1); sleep_exec = 0;
            chk(outs() == 9'b111_000_001, "R5", outs(), 9'b111_000_001);
            tick(1);
            chk(unsup_mode == 0, "R5 one cycle", unsup_mode, 0);
        end
        {cfg_iostop, cfg_ctl_a, cfg_ctl_b} = 3'b000;

        // R6: bus grant releases the park
        do_reset();
        sleep_exec = 1; tick(1); sleep_exec = 0;
        chk(addr_force_high == '1 && ctl_force_high, "R6 parked", ctl_force_high, 1);
        bus_granted = 1; tick(1);
        chk(addr_force_high == '0 && !ctl_force_high, "R6 granted", ctl_force_high, 0);
        bus_granted = 0;

        // R10: strobes ignored while asleep, then while halted
        halt_exec = 1; tick(1); halt_exec = 0; tick(1);
        chk(outs() == 9'b000_100_100, "R10 sleep", outs(), 9'b000_100_100);
        // R9: reset out of sleep
        do_reset();
        chk(outs() == 9'b111_000_000, "R9 sleep", outs(), 9'b111_000_000);
        halt_exec = 1; tick(1); halt_exec = 0;
        sleep_exec = 1; tick(1); sleep_exec = 0; tick(1);
        chk(outs() == 9'b111_111_000, "R10 halt", outs(), 9'b111_111_000);
        // R9: reset out of halt beats a pending request
        nmi_req = 1; rst_n = 0; tick(1);
        chk(outs() == 9'b111_000_000, "R9 halt", outs(), 9'b111_000_000);
        nmi_req = 0; rst_n = 1; tick(1);

        // R10: simultaneous strobes, halt wins
        do_reset();
        halt_exec = 1; sleep_exec = 1; tick(1); halt_exec = 0; sleep_exec = 0;
        chk(outs() == 9'b111_111_000, "R10 priority", outs(), 9'b111_111_000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule